// File: doc/BRIEF.md
# Ethernet Transmit Start/Stop Controller

This block decides, one frame at a time, when a MAC transmit engine may begin pulling a frame out of a host-filled transmit data FIFO. It supports two start rules. In buffered mode a frame starts only once the host has written its last byte. In early-start mode a frame starts once the FIFO holds a byte count taken from one of two four-entry tables, one for each line rate. A frame that is fully written also starts, even if it is shorter than the threshold.

The host controls the block through a single byte-wide write port. This port sets an enable bit, a graceful-stop request, a bit that lets transmission continue while the status FIFO is full, the start-rule selection and the threshold index. A stop request lets the frame on the wire finish. After that no frame starts, and both the stop bit and the enable bit clear themselves together. When the status FIFO is full, new frames are held back unless the overrun bit is set. A registered status-full interrupt line follows the full input regardless of that bit.

In early-start mode, the MAC can empty the FIFO before the host has written the frame's end. When that happens the block raises a sticky underrun flag, pulses an abort for the frame and drops back to idle.

Top module: `tx_ssc_top`

## Requirements
- R1: After reset the control readback `ctl_q` is 0, and `start_frame`, `frame_active`, `abort_frame`, `underrun` and `stat_irq` are 0.
- R2: While the enable bit (`cfg_wdata[0]`, `ctl_q[0]`) is 0, no frame starts, even when a complete frame is waiting.
- R3: With buffered mode set (`cfg_wdata[3]`), a waiting frame (`head_valid`=1) starts only once `tail_written` is 1. The FIFO level, threshold mode and threshold index are ignored in this mode.
- R4: With buffered mode clear, a waiting frame starts when `fifo_level` is at least the threshold, or when `tail_written` is 1. The threshold is 64·(idx+1) bytes when the rate bit (`cfg_wdata[4]`) is 1, and 512·(idx+3) bytes when it is 0. The index idx is `cfg_wdata[6:5]`.
- R5: `start_frame` is a one-cycle pulse, raised on the clock edge after the start condition holds. `frame_active` rises with it and falls on the edge after a `mac_done` pulse.
- R6: Once the stop bit (`cfg_wdata[1]`, `ctl_q[1]`) is set, the frame in progress completes without abort and no new frame starts. On the edge after the transmitter is idle with stop set, `ctl_q[1]` and `ctl_q[0]` both clear.
- R7: While the stop bit reads 1, a host write of 0 to it leaves it at 1.
- R8: When `stat_full` is 1 and the overrun bit (`cfg_wdata[2]`) is 0, no frame starts. When the overrun bit is 1, frames start despite `stat_full`.
- R9: `stat_irq` equals `stat_full` delayed by one cycle, whatever the overrun bit holds.
- R10: In early-start mode, if `fifo_level` is 0 while a frame is active, `tail_written` is 0 and `mac_done` is 0, then on the next edge `underrun` sets, `abort_frame` pulses for one cycle and `frame_active` falls. With `tail_written`=1, an empty FIFO does not abort.
- R11: `underrun` stays 1 until a host write with `cfg_wdata[7]`=1. Writes without that bit leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control write strobe |
| cfg_wdata | input | 8 | Control write data: [0] enable, [1] stop, [2] overrun allow, [3] buffered, [4] rate, [6:5] threshold index, [7] clear underrun |
| ctl_q | output | 7 | Control register readback, same bit layout as bits 6:0 of the write data |
| head_valid | input | 1 | A frame is present at the FIFO head |
| tail_written | input | 1 | The host has written the last byte of the head frame |
| fifo_level | input | LVL_W | Bytes currently held in the transmit data FIFO |
| mac_done | input | 1 | The MAC finished the current frame (pulse) |
| stat_full | input | 1 | Transmit status FIFO is full |
| start_frame | output | 1 | One-cycle start command to the MAC |
| frame_active | output | 1 | A frame is being transmitted |
| abort_frame | output | 1 | One-cycle pulse: current frame aborted by underrun |
| underrun | output | 1 | Sticky underrun flag |
| stat_irq | output | 1 | Status-FIFO-full interrupt line |

## Verification
The hardest case to reach from the ports is a stop request landing in the middle of a frame while a second complete frame is already waiting. In that case the block must finish the first frame, must not start the second, and only then self-clear both bits. The bench starts a frame, keeps a fully written frame pending and sets the stop bit. It then tries to clear that bit, and only afterwards pulses `mac_done`, checking the exact edge on which the control bits clear. Underrun is reached by starting an early-start frame at its threshold, then dropping the level to zero with the tail still unwritten.

// File: rtl/tx_ssc_pkg.sv
package tx_ssc_pkg;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  localparam int CFG_W    = 8;
  localparam int CTL_W    = 7;
  localparam int B_EN     = 0;
  localparam int B_STOP   = 1;
  localparam int B_ALLOW  = 2;
  localparam int B_BUF    = 3;
  localparam int B_RATE   = 4;
  localparam int B_IDX_LO = 5;
  localparam int B_IDX_HI = 6;
  localparam int B_CLRUR  = 7;

  // Threshold in bytes for a rate bit and a 2-bit index.
  function automatic logic [15:0] thr_bytes(input logic       rate_slow,
                                            input logic [1:0] idx,
                                            input logic [15:0] slow_step,
                                            input logic [15:0] fast_step,
                                            input logic [15:0] fast_ofs);
    logic [15:0] idx16;
    idx16 = {14'd0, idx};
    if (rate_slow) thr_bytes = slow_step * (idx16 + 16'd1);
    else           thr_bytes = fast_step * (idx16 + fast_ofs);
  endfunction

endpackage

// File: rtl/tx_ssc_cfg.sv
module tx_ssc_cfg
  import tx_ssc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  input  logic             halt_evt,
  output logic             en,
  output logic             stop,
  output logic             allow,
  output logic             buf_mode,
  output logic             rate_slow,
  output logic [1:0]       idx
);

  logic       en_q, stop_q, allow_q, buf_q, rate_q;
  logic [1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      stop_q  <= 1'b0;
      allow_q <= 1'b0;
      buf_q   <= 1'b0;
      rate_q  <= 1'b0;
      idx_q   <= 2'd0;
    end else begin
      if (wr_en) begin
        en_q    <= wdata[B_EN];
        allow_q <= wdata[B_ALLOW];
        buf_q   <= wdata[B_BUF];
        rate_q  <= wdata[B_RATE];
        idx_q   <= wdata[B_IDX_HI:B_IDX_LO];
        // a pending stop cannot be rewritten by the host
        if (!stop_q) stop_q <= wdata[B_STOP];
      end
      if (halt_evt) begin
        en_q   <= 1'b0;
        stop_q <= 1'b0;
      end
    end
  end

  assign en        = en_q;
  assign stop      = stop_q;
  assign allow     = allow_q;
  assign buf_mode  = buf_q;
  assign rate_slow = rate_q;
  assign idx       = idx_q;

endmodule

// File: rtl/tx_ssc_start_rule.sv
module tx_ssc_start_rule
  import tx_ssc_pkg::*;
#(
  parameter int LVL_W     = 14,
  parameter int SLOW_STEP = 64,
  parameter int FAST_STEP = 512,
  parameter int FAST_OFS  = 3
) (
  input  logic             buf_mode,
  input  logic             rate_slow,
  input  logic [1:0]       idx,
  input  logic             tail_written,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             data_ready,
  output logic [LVL_W-1:0] threshold
);

  localparam int NUM_IDX = 4;

  logic [LVL_W-1:0] tbl_slow [NUM_IDX];
  logic [LVL_W-1:0] tbl_fast [NUM_IDX];

  for (genvar g = 0; g < NUM_IDX; g++) begin : g_tbl
    assign tbl_slow[g] = LVL_W'(thr_bytes(1'b1, 2'(g), 16'(SLOW_STEP),
                                          16'(FAST_STEP), 16'(FAST_OFS)));
    assign tbl_fast[g] = LVL_W'(thr_bytes(1'b0, 2'(g), 16'(SLOW_STEP),
                                          16'(FAST_STEP), 16'(FAST_OFS)));
  end

  assign threshold = rate_slow ? tbl_slow[idx] : tbl_fast[idx];

  always_comb begin
    if (buf_mode) data_ready = tail_written;
    else          data_ready = tail_written || (fifo_level >= threshold);
  end

endmodule

// File: rtl/tx_ssc_fsm.sv
module tx_ssc_fsm
  import tx_ssc_pkg::*;
#(
  parameter int LVL_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             stop,
  input  logic             allow,
  input  logic             buf_mode,
  input  logic             head_valid,
  input  logic             data_ready,
  input  logic             tail_written,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             mac_done,
  input  logic             stat_full,
  input  logic             clr_underrun,
  output logic             start_evt,
  output logic             halt_evt,
  output logic             underrun_evt,
  output logic             start_frame,
  output logic             frame_active,
  output logic             abort_frame,
  output logic             underrun
);

  tx_state_e st_q;
  logic      start_q, abort_q, underrun_q;
  logic      stat_block;

  assign stat_block   = stat_full && !allow;
  assign start_evt    = (st_q == TX_IDLE) && en && !stop && head_valid &&
                        data_ready && !stat_block;
  assign halt_evt     = (st_q == TX_IDLE) && stop;
  assign underrun_evt = (st_q == TX_SEND) && !mac_done && !buf_mode &&
                        !tail_written && (fifo_level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= TX_IDLE;
      start_q    <= 1'b0;
      abort_q    <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      start_q <= start_evt;
      abort_q <= underrun_evt;
      unique case (st_q)
        TX_IDLE: if (start_evt) st_q <= TX_SEND;
        TX_SEND: if (mac_done || underrun_evt) st_q <= TX_IDLE;
        default: st_q <= TX_IDLE;
      endcase
      if (underrun_evt)      underrun_q <= 1'b1;
      else if (clr_underrun) underrun_q <= 1'b0;
    end
  end

  assign start_frame  = start_q;
  assign frame_active = (st_q == TX_SEND);
  assign abort_frame  = abort_q;
  assign underrun     = underrun_q;

endmodule

// File: rtl/tx_ssc_top.sv
module tx_ssc_top
  import tx_ssc_pkg::*;
#(
  parameter int LVL_W     = 14,
  parameter int SLOW_STEP = 64,
  parameter int FAST_STEP = 512,
  parameter int FAST_OFS  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [6:0]       ctl_q,
  input  logic             head_valid,
  input  logic             tail_written,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             mac_done,
  input  logic             stat_full,
  output logic             start_frame,
  output logic             frame_active,
  output logic             abort_frame,
  output logic             underrun,
  output logic             stat_irq
);

  logic             en, stop, allow, buf_mode, rate_slow;
  logic [1:0]       idx;
  logic             data_ready;
  logic [LVL_W-1:0] threshold;
  logic             start_evt, halt_evt, underrun_evt;
  logic             clr_underrun;
  logic             irq_q;

  assign clr_underrun = cfg_wr && cfg_wdata[B_CLRUR];

  tx_ssc_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .wdata     (cfg_wdata),
    .halt_evt  (halt_evt),
    .en        (en),
    .stop      (stop),
    .allow     (allow),
    .buf_mode  (buf_mode),
    .rate_slow (rate_slow),
    .idx       (idx)
  );

  tx_ssc_start_rule #(
    .LVL_W     (LVL_W),
    .SLOW_STEP (SLOW_STEP),
    .FAST_STEP (FAST_STEP),
    .FAST_OFS  (FAST_OFS)
  ) u_rule (
    .buf_mode     (buf_mode),
    .rate_slow    (rate_slow),
    .idx          (idx),
    .tail_written (tail_written),
    .fifo_level   (fifo_level),
    .data_ready   (data_ready),
    .threshold    (threshold)
  );

  tx_ssc_fsm #(.LVL_W(LVL_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .stop         (stop),
    .allow        (allow),
    .buf_mode     (buf_mode),
    .head_valid   (head_valid),
    .data_ready   (data_ready),
    .tail_written (tail_written),
    .fifo_level   (fifo_level),
    .mac_done     (mac_done),
    .stat_full    (stat_full),
    .clr_underrun (clr_underrun),
    .start_evt    (start_evt),
    .halt_evt     (halt_evt),
    .underrun_evt (underrun_evt),
    .start_frame  (start_frame),
    .frame_active (frame_active),
    .abort_frame  (abort_frame),
    .underrun     (underrun)
  );

  // interrupt line depends on the full input only, never on the overrun bit
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= stat_full;
  end

  assign stat_irq = irq_q;
  assign ctl_q    = {idx, rate_slow, buf_mode, allow, stop, en};

endmodule

// File: rtl/tx_ssc_chk.sv
module tx_ssc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_wdata,
  input logic [6:0] ctl_q,
  input logic       stat_full,
  input logic       start_frame,
  input logic       frame_active,
  input logic       abort_frame,
  input logic       underrun,
  input logic       stat_irq,
  input logic       halt_evt
);

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[0] |=> !start_frame); // R2
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_frame |=> !start_frame); // R5
  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start_frame |-> frame_active); // R5
  AST_NO_START_STOPPING: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] |=> !start_frame); // R6
  AST_HALT_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[1]) |-> !ctl_q[0]); // R6
  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[1] && !halt_evt |=> ctl_q[1]); // R7
  AST_STAT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    stat_full && !ctl_q[2] |=> !start_frame); // R8
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stat_full |=> stat_irq); // R9
  AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_full |=> !stat_irq); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_frame |-> underrun && !frame_active); // R10
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !(cfg_wr && cfg_wdata[7]) |=> underrun); // R11

endmodule

bind tx_ssc_top tx_ssc_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_wr       (cfg_wr),
  .cfg_wdata    (cfg_wdata),
  .ctl_q        (ctl_q),
  .stat_full    (stat_full),
  .start_frame  (start_frame),
  .frame_active (frame_active),
  .abort_frame  (abort_frame),
  .underrun     (underrun),
  .stat_irq     (stat_irq),
  .halt_evt     (halt_evt)
);

// File: tb/tx_ssc_top_bench.sv
`timescale 1ns/1ps
module tx_ssc_top_bench;

  localparam int LVL_W = 14;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_wr = 1'b0;
  logic [7:0]       cfg_wdata = 8'd0;
  logic [6:0]       ctl_q;
  logic             head_valid = 1'b0;
  logic             tail_written = 1'b0;
  logic [LVL_W-1:0] fifo_level = '0;
  logic             mac_done = 1'b0;
  logic             stat_full = 1'b0;
  logic             start_frame, frame_active, abort_frame, underrun, stat_irq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  tx_ssc_top u_tx_ssc_top (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .ctl_q(ctl_q), .head_valid(head_valid), .tail_written(tail_written),
    .fifo_level(fifo_level), .mac_done(mac_done), .stat_full(stat_full),
    .start_frame(start_frame), .frame_active(frame_active),
    .abort_frame(abort_frame), .underrun(underrun), .stat_irq(stat_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_wdata = 8'd0;
  endtask

  function automatic int cfgw(input int en, input int stp, input int alw,
                              input int bm, input int rt, input int ix);
    return en + 2*stp + 4*alw + 8*bm + 16*rt + 32*ix;
  endfunction

  function automatic int thr_of(input int rt, input int ix);
    if (rt == 1) return 64 * (ix + 1);
    return 512 * (ix + 3);
  endfunction

  task automatic finish_frame(input string req);
    head_valid = 1'b0; tail_written = 1'b0; mac_done = 1'b1;
    step(1);
    mac_done = 1'b0;
    chk(req, int'(frame_active), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1 ctl", int'(ctl_q), 0);
    chk("R1 start", int'(start_frame), 0);
    chk("R1 active", int'(frame_active), 0);
    chk("R1 underrun", int'(underrun), 0);
    chk("R1 irq", int'(stat_irq), 0);

    // R2 disabled: complete frame waits
    wr(8'(cfgw(0, 0, 0, 1, 0, 0)));
    head_valid = 1; tail_written = 1; fifo_level = 100;
    step(3);
    chk("R2 no start", int'(start_frame) + int'(frame_active), 0);
    head_valid = 0; tail_written = 0;

    // R3 buffered mode sweep: thresholds ignored
    for (int rt = 0; rt < 2; rt++) begin
      for (int ix = 0; ix < 4; ix++) begin
        wr(8'(cfgw(1, 0, 0, 1, rt, ix)));
        head_valid = 1; tail_written = 0; fifo_level = 14'd16000;
        step(2);
        chk("R3 wait tail", int'(frame_active), 0);
        tail_written = 1;
        step(1);
        chk("R3 start", int'(start_frame), 1);
        finish_frame("R5 done");
      end
    end

    // R4 threshold sweep
    for (int rt = 0; rt < 2; rt++) begin
      for (int ix = 0; ix < 4; ix++) begin
        wr(8'(cfgw(1, 0, 0, 0, rt, ix)));
        head_valid = 1; tail_written = 0; fifo_level = LVL_W'(thr_of(rt, ix) - 1);
        step(2);
        chk("R4 below", int'(frame_active), 0);
        fifo_level = LVL_W'(thr_of(rt, ix));
        step(1);
        chk("R4 at thr", int'(start_frame), 1);
        if (rt == 1 && ix == 3) begin
          step(1);
          chk("R5 pulse", int'(start_frame), 0);
          chk("R5 active", int'(frame_active), 1);
        end
        finish_frame("R5 done");
      end
    end
    // R4 short frame fully written below threshold
    wr(8'(cfgw(1, 0, 0, 0, 0, 3)));
    head_valid = 1; tail_written = 1; fifo_level = 10;
    step(1);
    chk("R4 short frame", int'(start_frame), 1);
    finish_frame("R5 done");

    // R8/R9 status backpressure
    wr(8'(cfgw(1, 0, 0, 1, 0, 0)));
    stat_full = 1; head_valid = 1; tail_written = 1;
    step(3);
    chk("R8 blocked", int'(frame_active), 0);
    chk("R9 irq no allow", int'(stat_irq), 1);
    wr(8'(cfgw(1, 0, 1, 1, 0, 0)));
    step(1);
    chk("R8 allowed", int'(start_frame), 1);
    chk("R9 irq allow", int'(stat_irq), 1);
    finish_frame("R5 done");
    stat_full = 0;
    step(1);
    chk("R9 irq clear", int'(stat_irq), 0);

    // R6/R7 stop during a frame with another frame pending
    wr(8'(cfgw(1, 0, 0, 1, 0, 0)));
    head_valid = 1; tail_written = 1;
    step(1);
    chk("R6 first start", int'(start_frame), 1);
    wr(8'(cfgw(1, 1, 0, 1, 0, 0)));
    step(2);
    chk("R6 stop held", int'(ctl_q[1]), 1);
    chk("R6 still active", int'(frame_active), 1);
    wr(8'(cfgw(1, 0, 0, 1, 0, 0)));
    chk("R7 stop ignores 0", int'(ctl_q[1]), 1);
    mac_done = 1;
    step(1);
    mac_done = 0;
    chk("R6 frame done", int'(frame_active) + int'(abort_frame), 0);
    step(1);
    chk("R6 self clear", int'(ctl_q[1:0]), 0);
    step(3);
    chk("R6 no new start", int'(frame_active), 0);
    head_valid = 0; tail_written = 0;

    // R6 stop while idle: exact edge
    wr(8'(cfgw(1, 1, 0, 1, 0, 0)));
    chk("R6 idle stop set", int'(ctl_q[1]), 1);
    step(1);
    chk("R6 idle halt", int'(ctl_q[1:0]), 0);

    // R10 underrun in early-start mode
    wr(8'(cfgw(1, 0, 0, 0, 1, 0)));
    head_valid = 1; tail_written = 0; fifo_level = 64;
    step(1);
    chk("R10 start", int'(start_frame), 1);
    head_valid = 0; fifo_level = 0;
    step(1);
    chk("R10 underrun", int'(underrun), 1);
    chk("R10 abort", int'(abort_frame), 1);
    chk("R10 idle", int'(frame_active), 0);
    step(1);
    chk("R10 abort pulse", int'(abort_frame), 0);

    // R11 sticky flag
    wr(8'(cfgw(1, 0, 0, 0, 1, 0)));
    chk("R11 kept", int'(underrun), 1);
    wr(8'(128 + cfgw(1, 0, 0, 0, 1, 0)));
    chk("R11 cleared", int'(underrun), 0);

    // R10 empty FIFO with tail written is no underrun
    head_valid = 1; tail_written = 1; fifo_level = 64;
    step(1);
    chk("R10 start2", int'(start_frame), 1);
    head_valid = 0; fifo_level = 0;
    step(2);
    chk("R10 no abort", int'(underrun) + int'(abort_frame), 0);
    chk("R10 still active", int'(frame_active), 1);
    finish_frame("R5 done");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule